// File: doc/BRIEF.md
# Serial Control Port Slave

This block lets an external host controller reach a 16-bit internal register space over four wires: an active-low select, a serial clock, serial data in and serial data out. The host sends each command as two 16-bit words. The first word carries a direction flag in its top bit and a 15-bit register address in the rest. The second word carries the write data, or the slot in which read data returns to the host.

All serial inputs are brought into the system clock domain through a synchronizer, and the serial clock edges are detected there. The internal side needs time between the two words of a command. A gap timer starts when an address word completes. A data word that begins before the timer runs out is dropped, and a sticky overrun flag is raised. For a read, the request goes to the register port as soon as the address word is in, so the fetched word is ready before the first data bit is due.

Top module: `scp_slave`

## Requirements
- R1: After reset `reg_wr_o`, `reg_rd_o`, `sdo_o` and `ovr_o` are 0.
- R2: A command whose address word has bit 15 = 0 produces exactly one single-cycle `reg_wr_o` pulse after its data word completes. `reg_addr_o` carries address word bits 14:0 and `reg_wdata_o` carries the data word. Both words are taken MSB first, with `sdi_i` sampled on rising `sck_i`.
- R3: An address word with bit 15 = 1 produces one single-cycle `reg_rd_o` pulse with `reg_addr_o` set, before any bit of the data word is clocked. No write strobe follows the command.
- R4: `reg_rdata_i` is sampled the cycle after `reg_rd_o`. It is presented MSB first on `sdo_o` during the data word. The first bit is valid before the first rising `sck_i` of that word, and later bits change after falling edges.
- R5: `sdo_o` is 0 during address words and during the data words of write commands.
- R6: Raising `cs_ni` discards a partial word and any pending command. The first full word after `cs_ni` falls again is treated as an address word.
- R7: If the first data-word bit arrives less than `GAP_CYCLES` clocks after the address word completes, that data word causes no write strobe and sets `ovr_o`.
- R8: Once set, `ovr_o` stays 1 until reset, and later commands still execute normally.
- R9: `reg_wr_o` and `reg_rd_o` are never high together, and neither stays high for two cycles in a row.
- R10: Commands may follow one another with `cs_ni` held low. The word after each data word is an address word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Serial select, active low |
| sck_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial data to host |
| reg_wr_o | output | 1 | Register write strobe |
| reg_rd_o | output | 1 | Register read request |
| reg_addr_o | output | 15 | Register address |
| reg_wdata_o | output | 16 | Register write data |
| reg_rdata_i | input | 16 | Register read data, valid the cycle after `reg_rd_o` |
| ovr_o | output | 1 | Sticky gap-violation flag |

## Verification
A bit counter that is off by one misaligns the address and the data word. This shows on the first command as a wrong `reg_addr_o` or `reg_wdata_o` value at the write strobe. A phase register stuck in the wrong state swaps the roles of the two words. That shows as a read request or a write strobe one word early or late. A transmit shifter that is not cleared or not loaded corrupts `sdo_o` within the next read data word, or drives it during write data. A gap timer with a wrong length either raises `ovr_o` on a properly spaced command or lets an early data word write. Both cases appear at the end of that one command.

// File: rtl/scp_pkg.sv
package scp_pkg;
  typedef enum logic {PH_ADDR = 1'b0, PH_DATA = 1'b1} phase_e;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st[s] <= RST_VAL;
      else if (s == 0) st[s] <= d_i;
      else st[s] <= st[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/scp_rx_shift.sv
module scp_rx_shift #(
  parameter int WORD_W = 16,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              rise_i,
  input  logic              sdi_i,
  output logic              first_bit_o,
  output logic [IDX_W-1:0]  bit_idx_o,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_W-1);

  logic [WORD_W-1:0] sr_q;
  logic [IDX_W-1:0]  cnt_q;

  assign first_bit_o = active_i & rise_i & (cnt_q == '0);
  assign bit_idx_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q       <= '0;
      cnt_q      <= '0;
      word_vld_o <= 1'b0;
      word_o     <= '0;
    end else begin
      word_vld_o <= 1'b0;
      if (!active_i) begin
        cnt_q <= '0;
        sr_q  <= '0;
      end else if (rise_i) begin
        sr_q  <= {sr_q[WORD_W-2:0], sdi_i};
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          word_vld_o <= 1'b1;
          word_o     <= {sr_q[WORD_W-2:0], sdi_i};
        end
      end
    end
  end
endmodule

// File: rtl/scp_gap_timer.sv
module scp_gap_timer #(
  parameter int GAP_CYCLES = 32,
  localparam int CNT_W = $clog2(GAP_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic clear_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clear_i)   cnt_q <= '0;
    else if (start_i)   cnt_q <= CNT_W'(GAP_CYCLES);
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/scp_slave.sv
module scp_slave #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int GAP_CYCLES  = 32,
  localparam int ADDR_W = WORD_W - 1,
  localparam int IDX_W  = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [WORD_W-1:0] reg_wdata_o,
  input  logic [WORD_W-1:0] reg_rdata_i,
  output logic              ovr_o
);
  import scp_pkg::*;

  logic [2:0] s_in;
  logic cs_n_s, sck_s, sdi_s, sck_q;
  logic active, rise, fall;

  scp_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sdi_i, sck_i, cs_ni}),
    .q_o   (s_in)
  );
  assign cs_n_s = s_in[0];
  assign sck_s  = s_in[1];
  assign sdi_s  = s_in[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_s;
  end

  assign active = ~cs_n_s;
  assign rise   = active & sck_s & ~sck_q;
  assign fall   = active & ~sck_s & sck_q;

  logic              first_bit, word_vld;
  logic [IDX_W-1:0]  bit_idx;
  logic [WORD_W-1:0] word;

  scp_rx_shift #(.WORD_W(WORD_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .rise_i     (rise),
    .sdi_i      (sdi_s),
    .first_bit_o(first_bit),
    .bit_idx_o  (bit_idx),
    .word_vld_o (word_vld),
    .word_o     (word)
  );

  phase_e phase_q;
  logic   gap_busy;

  scp_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(word_vld && phase_q == PH_ADDR),
    .clear_i(!active),
    .busy_o (gap_busy)
  );

  logic              rnw_q, early_q, ovr_q, wr_q, rd_q, rd_pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q, tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_ADDR;
      rnw_q     <= 1'b0;
      early_q   <= 1'b0;
      ovr_q     <= 1'b0;
      wr_q      <= 1'b0;
      rd_q      <= 1'b0;
      rd_pend_q <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      tx_q      <= '0;
    end else begin
      wr_q      <= 1'b0;
      rd_q      <= 1'b0;
      rd_pend_q <= rd_q;
      if (!active) begin
        phase_q <= PH_ADDR;
        early_q <= 1'b0;
        tx_q    <= '0;
      end else begin
        // data word started inside the access gap
        if (first_bit && phase_q == PH_DATA && gap_busy) early_q <= 1'b1;
        if (word_vld) begin
          if (phase_q == PH_ADDR) begin
            rnw_q   <= word[WORD_W-1];
            addr_q  <= word[ADDR_W-1:0];
            rd_q    <= word[WORD_W-1];
            phase_q <= PH_DATA;
          end else begin
            phase_q <= PH_ADDR;
            early_q <= 1'b0;
            tx_q    <= '0;
            if (early_q) ovr_q <= 1'b1;
            else if (!rnw_q) begin
              wr_q    <= 1'b1;
              wdata_q <= word;
            end
          end
        end else if (rd_pend_q && phase_q == PH_DATA) begin
          tx_q <= reg_rdata_i;
        end else if (fall && phase_q == PH_DATA && bit_idx != '0) begin
          tx_q <= {tx_q[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  assign sdo_o       = tx_q[WORD_W-1];
  assign reg_wr_o    = wr_q;
  assign reg_rd_o    = rd_q;
  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = wdata_q;
  assign ovr_o       = ovr_q;
endmodule

// File: rtl/scp_slave_chk.sv
module scp_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic reg_wr_o,
  input logic reg_rd_o,
  input logic ovr_o
);
  // R9
  wr_rd_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_o && reg_rd_o));
  // R9
  wr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);
  // R3
  rd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_o |=> !reg_rd_o);
  // R8
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |=> ovr_o);
  // R7
  ovr_no_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> !reg_wr_o);
endmodule

bind scp_slave scp_slave_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .reg_wr_o(reg_wr_o),
  .reg_rd_o(reg_rd_o),
  .ovr_o   (ovr_o)
);

// File: tb/tb_scp_slave.sv
module tb_scp_slave;
  localparam int HP  = 4;
  localparam int GAP = 32;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic sdo, reg_wr, reg_rd, ovr;
  logic [14:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;

  always #2.5 clk = ~clk;

  assign reg_rdata = {reg_addr[7:0], ~reg_addr[7:0]};

  scp_slave #(.GAP_CYCLES(GAP)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .reg_wr_o(reg_wr), .reg_rd_o(reg_rd), .reg_addr_o(reg_addr),
    .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata), .ovr_o(ovr)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [14:0] last_wa, last_ra;
  logic [15:0] last_wd;

  always @(negedge clk) begin
    if (reg_wr) begin wr_cnt++; last_wa = reg_addr; last_wd = reg_wdata; end
    if (reg_rd) begin rd_cnt++; last_ra = reg_addr; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_word(input logic [15:0] w, output logic [15:0] rx);
    for (int i = 15; i >= 0; i--) begin
      sdi = w[i];
      wait_clk(HP);
      rx[i] = sdo;
      sck = 1'b1;
      wait_clk(HP);
      sck = 1'b0;
    end
  endtask

  task automatic t_reset;
    // R1
    chk(reg_wr == 0 && reg_rd == 0, "R1 strobes", {reg_wr, reg_rd}, 0);
    chk(sdo == 0 && ovr == 0, "R1 sdo/ovr", {sdo, ovr}, 0);
  endtask

  task automatic t_write(input logic [14:0] a, input logic [15:0] d, input string req);
    logic [15:0] rx;
    int w0 = wr_cnt, r0 = rd_cnt;
    cs_ni = 1'b0;
    send_word({1'b0, a}, rx);
    chk(rx == 0, "R5 sdo in addr word", rx, 0);
    wait_clk(60);
    send_word(d, rx);
    chk(rx == 0, "R5 sdo in write data", rx, 0);
    wait_clk(6);
    chk(wr_cnt == w0 + 1, {req, " wr count"}, wr_cnt - w0, 1);
    chk(last_wa == a, {req, " wr addr"}, last_wa, a);
    chk(last_wd == d, {req, " wr data"}, last_wd, d);
    chk(rd_cnt == r0, "R9 no read on write", rd_cnt - r0, 0);
  endtask

  task automatic t_read(input logic [14:0] a);
    logic [15:0] rx, exp;
    int w0 = wr_cnt, r0 = rd_cnt;
    cs_ni = 1'b0;
    send_word({1'b1, a}, rx);
    wait_clk(4);
    chk(rd_cnt == r0 + 1, "R3 read request", rd_cnt - r0, 1);
    chk(last_ra == a, "R3 read addr", last_ra, a);
    wait_clk(56);
    send_word(16'h0000, rx);
    exp = {a[7:0], ~a[7:0]};
    chk(rx == exp, "R4 read data on sdo", rx, exp);
    wait_clk(6);
    chk(wr_cnt == w0, "R3 no write on read", wr_cnt - w0, 0);
    chk(sdo == 0, "R5 sdo idle after read", sdo, 0);
  endtask

  task automatic t_abort;
    logic [15:0] rx;
    cs_ni = 1'b0;
    for (int i = 0; i < 7; i++) begin
      sdi = 1'b1; wait_clk(HP); sck = 1'b1; wait_clk(HP); sck = 1'b0;
    end
    wait_clk(2);
    cs_ni = 1'b1;
    wait_clk(10);
    // R6: partial word gone, next word is address
    t_write(15'h0123, 16'hBEEF, "R6");
    // R6: abort after address word, pending command dropped
    send_word({1'b0, 15'h7777}, rx);
    wait_clk(4);
    cs_ni = 1'b1;
    wait_clk(10);
    t_write(15'h0456, 16'h1357, "R6 after cmd abort");
  endtask

  task automatic t_early;
    logic [15:0] rx;
    int w0 = wr_cnt;
    cs_ni = 1'b0;
    send_word({1'b0, 15'h0042}, rx);
    wait_clk(1);
    send_word(16'hDEAD, rx);
    wait_clk(6);
    chk(wr_cnt == w0, "R7 early data ignored", wr_cnt - w0, 0);
    chk(ovr == 1, "R7 overrun set", ovr, 1);
    t_write(15'h0011, 16'h2222, "R8 after overrun");
    chk(ovr == 1, "R8 overrun sticky", ovr, 1);
  endtask

  task automatic t_b2b;
    // R10: commands chained with select held low
    t_write(15'h7FFF, 16'hFFFF, "R10 b2b 1");
    t_read(15'h00C3);
    t_write(15'h0000, 16'h0001, "R10 b2b 2");
    t_read(15'h7A5A);
  endtask

  initial begin
    wait_clk(3);
    t_reset;
    rst_ni = 1'b1;
    wait_clk(3);
    t_reset;
    t_write(15'h1234, 16'hA5C3, "R2");
    t_write(15'h4001, 16'h8000, "R2 msb");
    cs_ni = 1'b1; wait_clk(8);
    t_read(15'h0155);
    t_b2b;
    cs_ni = 1'b1; wait_clk(8);
    t_abort;
    cs_ni = 1'b1; wait_clk(8);
    t_early;
    cs_ni = 1'b1; wait_clk(8);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule